// File: doc/BRIEF.md
# Stop-Mode Wake-Up Source Detector

This block decides when a stopped low-power controller should wake. Software programs a write-only control byte. The byte holds a recovery-level bit and a 3-bit source code. The source code picks one of eight fixed pin groupings taken from three 8-bit input ports. The selected pins are combined through a NAND or a NOR gate. While the core is in stop mode, the block emits a single-cycle wake pulse when the gate result equals the programmed level.

The block skips any pin whose direction bit marks it as an output. Such a pin is replaced by the neutral value of its gate, so it cannot change the result. If every pin of the chosen group is an output, the block never wakes. Pin inputs pass through a synchronizer before the gate. A further pulse needs the match to drop and come back. The block does not restart the oscillator, gate clocks or sequence the core.

Top module: `wake_src_detect`

## Requirements
- R1: After power-on reset (`porN` low), `wakePulse` is 0. The stored level is 0 and the stored source code is 000.
- R2: With source code 000 (bits 4:2 of `cfgData`), no pin pattern ever produces a wake pulse.
- R3: The NAND codes are 001 (port 2 pins 3..0), 010 (all of port 2) and 100 (port 3 pins 3..1).
- R4: Code 011 selects the NOR of port 3 pins 3..1.
- R5: Code 101 selects the NOR of port 3 pins 3..1 together with port 0 pins 0 and 7. Code 110 selects the NAND of the same five pins.
- R6: Code 111 selects the NAND of port 3 pins 3..1 together with port 2 pins 2..0.
- R7: Bit 6 of `cfgData` is the level. With level 0 the block wakes on a low gate result; with level 1 it wakes on a high result.
- R8: A pin whose direction bit is 1 (output) does not affect the gate. A group whose pins are all outputs never wakes.
- R9: `wakePulse` lasts exactly one cycle. It is only raised when `stopMode` was high in the preceding cycle. A new pulse requires the match to drop first.
- R10: A pin change applied before clock edge k makes `wakePulse` high after edge k+2 and not before.
- R11: Bits 7, 5, 1 and 0 of `cfgData` are ignored on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| p0In | input | 8 | Port 0 pin values |
| p2In | input | 8 | Port 2 pin values |
| p3In | input | 8 | Port 3 pin values |
| p0Dir | input | 8 | Port 0 direction, 1 = output |
| p2Dir | input | 8 | Port 2 direction, 1 = output |
| p3Dir | input | 8 | Port 3 direction, 1 = output |
| stopMode | input | 1 | Core is in stop mode |
| cfgWe | input | 1 | Control byte write strobe |
| cfgData | input | 8 | Control byte write data |
| wakePulse | output | 1 | Single-cycle wake request |

## Verification
On every cycle, the assertions check four things. A pulse lasts one cycle. A pulse follows a cycle with stop mode asserted. Source code 000 never wakes. A fully output-configured nibble on code 001 never wakes. Only the bench scenarios can show the rest: the gate polarity of each source code, the level comparison, the exclusion of single output pins, the ignored reserved bits and the exact two-edge synchronizer latency. A behavioural model in the bench tracks all of these cycle by cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int PORT_W  = 8;
  localparam int NPORTS  = 3;
  localparam int PINS_W  = PORT_W * NPORTS;
  localparam int SRC_W   = 3;
  localparam int LVL_BIT = 6;
  localparam int SRC_LSB = 2;

  typedef struct packed {
    logic              armed;
    logic              useNor;
    logic [PINS_W-1:0] pinSel;
  } wakeCtrl_t;

  // pin bus layout: {port3, port2, port0}
  function automatic logic [PINS_W-1:0] groupMask(input logic [SRC_W-1:0] code);
    logic [PORT_W-1:0] m0, m2, m3;
    m0 = '0; m2 = '0; m3 = '0;
    case (code)
      3'd1: m2 = 8'h0F;
      3'd2: m2 = 8'hFF;
      3'd3, 3'd4: m3 = 8'h0E;
      3'd5, 3'd6: begin m3 = 8'h0E; m0 = 8'h81; end
      3'd7: begin m3 = 8'h0E; m2 = 8'h07; end
      default: ;
    endcase
    return {m3, m2, m0};
  endfunction

  function automatic logic gateIsNor(input logic [SRC_W-1:0] code);
    return (code == 3'd3) || (code == 3'd5);
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) stg <= '0;
        else       stg <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) stg <= '0;
        else       stg <= {stg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [PINS_W-1:0] pinsRaw,
  input  logic [PINS_W-1:0] pinsDir,
  input  wakeCtrl_t         ctrl,
  output logic              gateOut,
  output logic              groupLive
);
  logic [PINS_W-1:0] pinsSync;
  logic [PINS_W-1:0] effSel;

  wake_sync #(.WIDTH(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .porN (porN),
    .din  (pinsRaw),
    .dout (pinsSync)
  );

  always_comb begin
    effSel    = ctrl.pinSel & ~pinsDir;
    groupLive = |effSel;
    if (ctrl.useNor) gateOut = ~|(pinsSync & effSel);
    else             gateOut = ~&(pinsSync | ~effSel);
  end
endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       cfgWe,
  input  logic [7:0] cfgData,
  input  logic       stopMode,
  input  logic       gateOut,
  input  logic       groupLive,
  output wakeCtrl_t  ctrl,
  output logic       wakePulse
);
  logic             lvlReg;
  logic [SRC_W-1:0] srcReg;
  logic             matchNow, matchPrev;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      lvlReg <= 1'b0;
      srcReg <= '0;
    end else if (cfgWe) begin
      lvlReg <= cfgData[LVL_BIT];
      srcReg <= cfgData[SRC_LSB +: SRC_W];
    end
  end

  always_comb begin
    ctrl.armed  = (srcReg != '0);
    ctrl.useNor = gateIsNor(srcReg);
    ctrl.pinSel = groupMask(srcReg);
    matchNow    = stopMode && ctrl.armed && groupLive && (gateOut == lvlReg);
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      matchPrev <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      matchPrev <= matchNow;
      wakePulse <= matchNow && !matchPrev;
    end
  end
endmodule

// File: rtl/wake_src_detect.sv
module wake_src_detect
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic [7:0] p0In,
  input  logic [7:0] p2In,
  input  logic [7:0] p3In,
  input  logic [7:0] p0Dir,
  input  logic [7:0] p2Dir,
  input  logic [7:0] p3Dir,
  input  logic       stopMode,
  input  logic       cfgWe,
  input  logic [7:0] cfgData,
  output logic       wakePulse
);
  wakeCtrl_t ctrlBus;
  logic      gateOut, groupLive;

  wake_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .porN      (porN),
    .pinsRaw   ({p3In, p2In, p0In}),
    .pinsDir   ({p3Dir, p2Dir, p0Dir}),
    .ctrl      (ctrlBus),
    .gateOut   (gateOut),
    .groupLive (groupLive)
  );

  wake_control u_ctrl (
    .clk       (clk),
    .porN      (porN),
    .cfgWe     (cfgWe),
    .cfgData   (cfgData),
    .stopMode  (stopMode),
    .gateOut   (gateOut),
    .groupLive (groupLive),
    .ctrl      (ctrlBus),
    .wakePulse (wakePulse)
  );
endmodule

// File: rtl/wake_src_detect_chk.sv
module wake_src_detect_chk (
  input logic       clk,
  input logic       porN,
  input logic [7:0] p2Dir,
  input logic       stopMode,
  input logic       cfgWe,
  input logic [7:0] cfgData,
  input logic       wakePulse
);
  logic [2:0] shadowSrc;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)      shadowSrc <= 3'd0;
    else if (cfgWe) shadowSrc <= cfgData[4:2];
  end

  p_single_cycle_r9: assert property (@(posedge clk) disable iff (!porN)
    wakePulse |=> !wakePulse);

  p_stop_required_r9: assert property (@(posedge clk) disable iff (!porN)
    wakePulse |-> $past(stopMode));

  p_por_only_r2: assert property (@(posedge clk) disable iff (!porN)
    ($past(shadowSrc) == 3'd0) |-> !wakePulse);

  p_all_outputs_r8: assert property (@(posedge clk) disable iff (!porN)
    ($past(shadowSrc) == 3'd1 && $past(p2Dir[3:0]) == 4'hF) |-> !wakePulse);
endmodule

bind wake_src_detect wake_src_detect_chk u_chk (
  .clk       (clk),
  .porN      (porN),
  .p2Dir     (p2Dir),
  .stopMode  (stopMode),
  .cfgWe     (cfgWe),
  .cfgData   (cfgData),
  .wakePulse (wakePulse)
);

// File: tb/wake_src_detect_bench.sv
module wake_src_detect_bench;
  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [7:0] p0In = 0, p2In = 0, p3In = 0;
  logic [7:0] p0Dir = 0, p2Dir = 0, p3Dir = 0;
  logic       stopMode = 1'b0, cfgWe = 1'b0;
  logic [7:0] cfgData = 0;
  logic       wakePulse;

  int    nChecks = 0, nErrors = 0, pulseCnt = 0;
  bit    running = 0, finished = 0;
  string curReq = "R1";

  always #10 clk = ~clk;  // 50 MHz

  wake_src_detect u_wake_src_detect (.*);

  // behavioural reference model
  int  mS1[3], mS2[3];
  int  mLevel = 0, mSrc = 0;
  bit  mPrev = 0, mPulse = 0;

  function automatic bit modelMatch(input int src, input int lvl, input bit stop);
    int pList[$], bList[$];
    int dirs[3], vals[3];
    bit useNor, any, acc;
    dirs[0] = p0Dir; dirs[1] = p2Dir; dirs[2] = p3Dir;
    vals = mS2;
    useNor = (src == 3) || (src == 5);
    if (src == 1) for (int b = 0; b < 4; b++) begin pList.push_back(1); bList.push_back(b); end
    if (src == 2) for (int b = 0; b < 8; b++) begin pList.push_back(1); bList.push_back(b); end
    if (src >= 3) for (int b = 1; b < 4; b++) begin pList.push_back(2); bList.push_back(b); end
    if (src == 5 || src == 6) begin
      pList.push_back(0); bList.push_back(0);
      pList.push_back(0); bList.push_back(7);
    end
    if (src == 7) for (int b = 0; b < 3; b++) begin pList.push_back(1); bList.push_back(b); end
    any = 0;
    acc = useNor ? 0 : 1;
    foreach (pList[i]) begin
      if (((dirs[pList[i]] >> bList[i]) & 1) == 0) begin
        any = 1;
        if (useNor) acc = acc | bit'((vals[pList[i]] >> bList[i]) & 1);
        else        acc = acc & bit'((vals[pList[i]] >> bList[i]) & 1);
      end
    end
    return stop && any && (int'(!acc) == lvl);
  endfunction

  always @(posedge clk) begin
    if (!porN) begin
      mS1 = '{0, 0, 0}; mS2 = '{0, 0, 0};
      mLevel = 0; mSrc = 0; mPrev = 0; mPulse = 0;
    end else begin
      bit m;
      m = modelMatch(mSrc, mLevel, stopMode);
      mPulse = m && !mPrev;
      mPrev  = m;
      mS2 = mS1;
      mS1[0] = p0In; mS1[1] = p2In; mS1[2] = p3In;
      if (cfgWe) begin mLevel = cfgData[6]; mSrc = cfgData[4:2]; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && porN) begin
      chk({curReq, " model"}, int'(wakePulse), int'(mPulse));
      if (wakePulse) pulseCnt++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input logic [7:0] d);
    @(negedge clk); cfgWe = 1; cfgData = d;
    @(negedge clk); cfgWe = 0; cfgData = 0;
  endtask

  task automatic setPins(input logic [7:0] a0, input logic [7:0] a2, input logic [7:0] a3);
    p0In = a0; p2In = a2; p3In = a3;
  endtask

  // quiet pattern, then trigger pattern; count pulses after trigger
  task automatic runCase(input string tag, input logic [7:0] cfg,
                         input logic [7:0] q0, input logic [7:0] q2, input logic [7:0] q3,
                         input logic [7:0] t0, input logic [7:0] t2, input logic [7:0] t3,
                         input int expCnt);
    int base;
    curReq = tag;
    setPins(q0, q2, q3);
    writeCfg(cfg);
    idle(5);
    base = pulseCnt;
    setPins(t0, t2, t3);
    idle(6);
    chk({tag, " pulse count"}, pulseCnt - base, expCnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int base;
    idle(3);
    chk("R1 reset output", int'(wakePulse), 0);
    porN = 1;
    running = 1;
    idle(2);
    chk("R1 after release", int'(wakePulse), 0);

    // R2: default code 000, pins toggling in stop mode
    curReq = "R2";
    stopMode = 1;
    base = pulseCnt;
    setPins(8'hFF, 8'hFF, 8'hFF); idle(4);
    setPins(8'h00, 8'h00, 8'h00); idle(4);
    chk("R2 por-only count", pulseCnt - base, 0);

    // R3 NAND groups
    runCase("R3 code001", 8'h04, 0, 8'h00, 0, 0, 8'h0F, 0, 1);
    runCase("R3 code010", 8'h48, 0, 8'hFF, 0, 0, 8'hFE, 0, 1);
    runCase("R3 code100", 8'h10, 0, 0, 8'h00, 0, 0, 8'h0E, 1);
    // R4 NOR of port3 3..1
    runCase("R4 code011", 8'h4C, 0, 0, 8'h0E, 0, 0, 8'h00, 1);
    // R5 with port0 pins 0 and 7
    runCase("R5 code101", 8'h54, 8'h81, 0, 8'h00, 8'h7E, 0, 8'h00, 1);
    runCase("R5 code110", 8'h18, 8'h80, 0, 8'h0E, 8'h81, 0, 8'h0E, 1);
    // R6 with port2 pins 2..0
    runCase("R6 code111", 8'h1C, 0, 8'h03, 8'h0E, 0, 8'h07, 8'h0E, 1);
    // R7 level high on code 001
    runCase("R7 level1", 8'h44, 0, 8'h0F, 0, 0, 8'h0E, 0, 1);
    runCase("R7 level1 no", 8'h44, 0, 8'h0E, 0, 0, 8'h0F, 0, 0);

    // R8 one output pin excluded
    p2Dir = 8'h01;
    runCase("R8 excluded pin", 8'h04, 0, 8'h00, 0, 0, 8'h0E, 0, 1);
    // R8 all pins of group outputs
    p2Dir = 8'h0F;
    runCase("R8 all outputs", 8'h04, 0, 8'h0F, 0, 0, 8'h00, 0, 0);
    p2Dir = 8'h00;

    // R9: no pulse out of stop mode, one pulse on entry, re-arm on drop
    curReq = "R9";
    stopMode = 0;
    setPins(0, 8'h00, 0);
    writeCfg(8'h04);
    idle(4);
    base = pulseCnt;
    setPins(0, 8'h0F, 0); idle(6);
    chk("R9 stop low", pulseCnt - base, 0);
    stopMode = 1; idle(8);
    chk("R9 single pulse held match", pulseCnt - base, 1);
    setPins(0, 8'h07, 0); idle(4);
    setPins(0, 8'h0F, 0); idle(6);
    chk("R9 re-arm", pulseCnt - base, 2);

    // R10 latency
    curReq = "R10";
    setPins(0, 8'h00, 0); idle(5);
    setPins(0, 8'h0F, 0);
    @(negedge clk); chk("R10 edge k", int'(wakePulse), 0);
    @(negedge clk); chk("R10 edge k+1", int'(wakePulse), 0);
    @(negedge clk); chk("R10 edge k+2", int'(wakePulse), 1);
    idle(3);

    // R11 reserved bits set with code 001 level 0
    runCase("R11 reserved ignored", 8'hA7, 0, 8'h00, 0, 0, 8'h0F, 0, 1);
    // R11 reserved set with code 000 stays por-only
    runCase("R11 reserved only", 8'hA3, 0, 8'h00, 0, 0, 8'h0F, 0, 0);

    running = 0;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule